// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several software localities owns a shared security device, and holds the 8-bit ownership register that each locality sees in its own register window. Software selects a locality number on a simple register port. It can then write a control byte or read back a status byte. The byte read back tells the locality whether the register is valid, whether it owns the device, whether ownership was taken from it, whether others are waiting, whether it is waiting itself, and whether a trusted OS has been set up.

A locality asks for the device by writing its request bit. If the device is free it becomes the owner in the same update. Otherwise its request waits until the owner gives the device up, and the highest-numbered waiting locality then takes over. A higher locality can seize the device from a lower owner. The owner that loses the device keeps a sticky flag until it clears the flag itself. The current owner is also given to the rest of the chip on dedicated outputs.

Top module: `loc_access_arbiter`

## Requirements
- R1: A read of any locality number below NUM_LOC returns bit 7 = 1, while bits 6 and 3 read 0.
- R2: Bit 5 (owner) reads 1 only in the byte of the owning locality. owner_valid/owner_loc give the same owner, and an owner never has its own request bit set.
- R3: Writing a byte with bit 1 (request) set registers a request. If the device is free, that locality owns it after the clock edge. Otherwise bit 1 of its own byte reads 1 while it waits. A request from the owner itself is ignored.
- R4: Writing bit 3 (seize) makes the writer the owner after the edge when the device is free, or when the writer's number is higher than the owner's.
- R5: A locality that loses ownership through a seize gets bit 4 (lost) set. The bit stays set until that locality writes 1 to bit 4.
- R6: Bit 2 (waiting) reads 1 when any locality other than the reader has an outstanding request.
- R7: The owner writing 1 to bit 5 frees the device. In the same update, the highest-numbered waiting locality becomes owner. With no requests, no locality owns the device.
- R8: Bit 0 reads as the inverse of the trusted_env_set input.
- R9: A seize from a locality that is not higher than the owner is ignored, and so is a bit-5 write from a locality that does not own the device.
- R10: After reset no locality owns the device, and every lost, request and waiting bit reads 0.
- R11: A locality number of NUM_LOC or above has writes ignored, and reads of it return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_loc | input | LOC_W (3) | Locality number selecting the register window |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data for the ownership register |
| trusted_env_set | input | 1 | High once a trusted OS is established |
| reg_rdata | output | 8 | Ownership register of locality reg_loc (combinational) |
| owner_valid | output | 1 | Some locality owns the device |
| owner_loc | output | LOC_W (3) | Number of the owning locality |

## Verification
The arbitration is driven with several request orders:
- A first request to a free device separates an immediate grant from queueing.
- A lower locality requesting behind an owner exercises the request and waiting bits seen from both sides.
- Two waiting localities at release show whether the handoff picks the highest number rather than the earliest request.

Seizes are tried from a higher locality, a lower locality, the owner itself and a free device. This separates the number comparison from plain write decoding. Writes and reads with out-of-range locality numbers, and toggling of the trusted-OS input, confirm that neither disturbs the ownership state.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    localparam int ACC_W       = 8;
    localparam int BIT_OK      = 7;
    localparam int BIT_OWNER   = 5;
    localparam int BIT_LOST    = 4;
    localparam int BIT_TAKE    = 3;
    localparam int BIT_WAITING = 2;
    localparam int BIT_ASK     = 1;
    localparam int BIT_NOTRUST = 0;

    typedef struct packed {
        logic relinquish;
        logic take;
        logic ask;
        logic clear_lost;
    } wr_cmd_t;

endpackage

// File: rtl/loc_arb_wr_decode.sv
module loc_arb_wr_decode
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [LOC_W-1:0]   reg_loc,
    input  logic               reg_wr,
    input  logic [ACC_W-1:0]   reg_wdata,
    output logic               loc_ok,
    output logic               wr_en,
    output wr_cmd_t            cmd
);

    always_comb begin
        loc_ok         = ({1'b0, reg_loc} < (LOC_W+1)'(NUM_LOC));
        wr_en          = reg_wr && loc_ok;
        cmd.relinquish = reg_wdata[BIT_OWNER];
        cmd.take       = reg_wdata[BIT_TAKE];
        cmd.ask        = reg_wdata[BIT_ASK];
        cmd.clear_lost = reg_wdata[BIT_LOST];
    end

endmodule

// File: rtl/loc_arb_pick_high.sv
module loc_arb_pick_high #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/loc_arb_read_fmt.sv
module loc_arb_read_fmt
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [LOC_W-1:0]   rd_loc,
    input  logic               rd_ok,
    input  logic               owner_vld,
    input  logic [LOC_W-1:0]   owner_id,
    input  logic [NUM_LOC-1:0] req,
    input  logic [NUM_LOC-1:0] lost,
    input  logic               trusted_env_set,
    output logic [ACC_W-1:0]   rdata
);

    logic [NUM_LOC-1:0] others_req;
    logic [NUM_LOC-1:0] own_sel;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_sel
        assign own_sel[g]    = (rd_loc == LOC_W'(g));
        assign others_req[g] = req[g] && !own_sel[g];
    end

    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            rdata[BIT_OK]      = 1'b1;
            rdata[BIT_OWNER]   = owner_vld && (owner_id == rd_loc);
            rdata[BIT_LOST]    = |(lost & own_sel);
            rdata[BIT_WAITING] = |others_req;
            rdata[BIT_ASK]     = |(req & own_sel);
            rdata[BIT_NOTRUST] = !trusted_env_set;
        end
    end

endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOC_W-1:0] reg_loc,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    input  logic             trusted_env_set,
    output logic [7:0]       reg_rdata,
    output logic             owner_valid,
    output logic [LOC_W-1:0] owner_loc
);

    typedef struct packed {
        logic               owner_vld;
        logic [LOC_W-1:0]   owner_id;
        logic [NUM_LOC-1:0] req;
        logic [NUM_LOC-1:0] lost;
    } state_t;

    state_t  st_q, st_m, st_d;
    logic    loc_ok, wr_en;
    wr_cmd_t cmd;
    logic    wait_any;
    logic [LOC_W-1:0] wait_top;

    loc_arb_wr_decode #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) i_dec (
        .reg_loc  (reg_loc),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .loc_ok   (loc_ok),
        .wr_en    (wr_en),
        .cmd      (cmd)
    );

    // Apply one write: relinquish, then seize, then request, in that order.
    always_comb begin
        st_m = st_q;
        if (wr_en) begin
            if (cmd.clear_lost) st_m.lost[reg_loc] = 1'b0;
            if (cmd.relinquish && st_q.owner_vld && st_q.owner_id == reg_loc)
                st_m.owner_vld = 1'b0;
            if (cmd.take && (!st_m.owner_vld || reg_loc > st_m.owner_id)) begin
                if (st_m.owner_vld) st_m.lost[st_m.owner_id] = 1'b1;
                st_m.owner_vld     = 1'b1;
                st_m.owner_id      = reg_loc;
                st_m.req[reg_loc]  = 1'b0;
            end
            if (cmd.ask && !(st_m.owner_vld && st_m.owner_id == reg_loc))
                st_m.req[reg_loc] = 1'b1;
        end
    end

    loc_arb_pick_high #(.N(NUM_LOC), .IDX_W(LOC_W)) i_pick (
        .vec(st_m.req),
        .any(wait_any),
        .idx(wait_top)
    );

    // Hand a free device to the highest waiting locality in the same update.
    always_comb begin
        st_d = st_m;
        if (!st_m.owner_vld && wait_any) begin
            st_d.owner_vld     = 1'b1;
            st_d.owner_id      = wait_top;
            st_d.req[wait_top] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    loc_arb_read_fmt #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) i_rd (
        .rd_loc         (reg_loc),
        .rd_ok          (loc_ok),
        .owner_vld      (st_q.owner_vld),
        .owner_id       (st_q.owner_id),
        .req            (st_q.req),
        .lost           (st_q.lost),
        .trusted_env_set(trusted_env_set),
        .rdata          (reg_rdata)
    );

    assign owner_valid = st_q.owner_vld;
    assign owner_loc   = st_q.owner_id;

    // R2: owner is a legal locality and never also waiting
    p_owner_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        owner_valid |-> (({1'b0, owner_loc} < (LOC_W+1)'(NUM_LOC)) && !st_q.req[owner_loc]));

    // R7: a free device never leaves a request waiting
    p_free_no_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_valid |-> (st_q.req == '0));

    // R4: seize by a higher locality takes ownership
    p_take_higher_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_wdata == 8'h08 && owner_valid && reg_loc > owner_loc)
        |=> (owner_valid && owner_loc == $past(reg_loc)));

    // R5: the loser of a seize is marked
    p_lost_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_wdata == 8'h08 && owner_valid && reg_loc > owner_loc)
        |=> st_q.lost[$past(owner_loc)]);

    // R9: seize from a locality not above the owner is ignored
    p_take_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_wdata == 8'h08 && owner_valid && reg_loc <= owner_loc)
        |=> (owner_valid && owner_loc == $past(owner_loc)));

    // R11: writes to an out-of-range locality change nothing
    p_oor_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !loc_ok) |=> $stable(st_q));

endmodule

// File: tb/test_loc_access_arbiter.sv
`timescale 1ns/1ps
module test_loc_access_arbiter;

    localparam int LOC_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LOC_W-1:0] reg_loc = '0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic             trusted_env_set = 1'b0;
    logic [7:0]       reg_rdata;
    logic             owner_valid;
    logic [LOC_W-1:0] owner_loc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    loc_access_arbiter i_loc_access_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_loc(reg_loc), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .trusted_env_set(trusted_env_set),
        .reg_rdata(reg_rdata), .owner_valid(owner_valid), .owner_loc(owner_loc)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(int loc, logic [7:0] d);
        @(negedge clk);
        reg_loc = LOC_W'(loc); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(string tag, int loc, logic [7:0] exp);
        reg_loc = LOC_W'(loc);
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic own(string tag, bit v, int loc);
        chk(tag, owner_valid, v);
        if (v) chk(tag, owner_loc, loc);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 5; i++) rd("R10 reset read", i, 8'h81);
        own("R10 reset owner", 0, 0);
    endtask

    task automatic t_request();
        wr(1, 8'h02);
        rd("R3 grant when free", 1, 8'hA1);
        rd("R2 non-owner reads no owner bit", 0, 8'h81);
        own("R2 owner outputs", 1, 1);
        wr(1, 8'h02);
        rd("R3 owner request ignored", 1, 8'hA1);
    endtask

    task automatic t_pending();
        wr(0, 8'h02);
        rd("R3 waiting request bit", 0, 8'h83);
        rd("R6 owner sees waiting", 1, 8'hA5);
        rd("R6 bystander sees waiting", 4, 8'h85);
    endtask

    task automatic t_seize();
        wr(3, 8'h08);
        own("R4 higher seize owner", 1, 3);
        rd("R5 loser marked", 1, 8'h95);
        rd("R4 new owner byte", 3, 8'hA5);
    endtask

    task automatic t_seize_ignored();
        wr(2, 8'h08);
        own("R9 lower seize ignored", 1, 3);
        rd("R9 lower seizer unchanged", 2, 8'h85);
        wr(3, 8'h08);
        own("R9 self seize ignored", 1, 3);
        rd("R9 self seize no lost", 3, 8'hA5);
    endtask

    task automatic t_relinquish();
        wr(1, 8'h20);
        own("R9 non-owner release ignored", 1, 3);
        wr(2, 8'h02);
        wr(3, 8'h20);
        own("R7 highest waiter granted", 1, 2);
        rd("R7 previous owner freed", 3, 8'h85);
        rd("R7 low waiter still waiting", 0, 8'h83);
    endtask

    task automatic t_lost_clear();
        wr(1, 8'h10);
        rd("R5 lost cleared", 1, 8'h85);
    endtask

    task automatic t_establish();
        trusted_env_set = 1'b1;
        rd("R8 trusted set", 4, 8'h84);
        trusted_env_set = 1'b0;
        rd("R8 trusted clear", 4, 8'h85);
    endtask

    task automatic t_out_of_range();
        wr(5, 8'h08);
        own("R11 write ignored", 1, 2);
        wr(7, 8'h22);
        own("R11 write ignored 7", 1, 2);
        rd("R11 read zero", 5, 8'h00);
        rd("R11 read zero 7", 7, 8'h00);
        rd("R1 valid bit set, 6 and 3 clear", 2, 8'hA5);
    endtask

    task automatic t_drain();
        wr(2, 8'h20);
        own("R7 last waiter granted", 1, 0);
        wr(0, 8'h20);
        own("R7 no owner when empty", 0, 0);
        rd("R6 no waiting when empty", 3, 8'h81);
        wr(4, 8'h08);
        own("R4 seize when free", 1, 4);
        rd("R4 free seize no lost", 0, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_request();
        t_pending();
        t_seize();
        t_seize_ignored();
        t_relinquish();
        t_lost_clear();
        t_establish();
        t_out_of_range();
        t_drain();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule